// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Merged Interrupt

This block is a bank of sixteen general-purpose pins controlled through a small register port. Software sets the direction and the output level of each pin and reads back the synchronized pin levels. A two-bit control register gates the bank's internal clock and holds the bank in a soft reset. Writing 3 and then 1 brings the bank up. Writing 2 parks it in the low-power state.

The lower eight pins each drive a dedicated interrupt request line. The upper eight pins are each masked by their own enable bit, and the masked levels are ORed into one active-high shared request. The interrupt output is nine bits wide. Bit 8 carries the shared request. All requests are level signals taken from the synchronized pins.

Top module: `gpio_bank_irq`

## Requirements
- R1: For each pin, a 1 in the direction register (address 1) drives `pad_oe` high for that pin, and `pad_out` follows the output register (address 2).
- R2: The control register (address 0) uses bit 0 for the clock enable and bit 1 for the soft reset. After `rst_n` it reads 2 (reset held, clock stopped).
- R3: While control bit 1 is set, the direction, output and mask registers read 0 and ignore writes, and the synchronizer is cleared.
- R4: Writing 3 and then 1 to the control register leaves the bank running, and later writes to direction, output and mask take effect.
- R5: While the control register is 0 (clock stopped, not in reset), writes to direction, output and mask are ignored and the pin-state reading is frozen.
- R6: A pad level reaches the pin-state register (address 3) and the interrupt outputs through two flops. It is visible after the second rising edge following the change.
- R7: `irq[i]` for i in 0..7 equals the synchronized level of pin i.
- R8: `irq[8]` is high exactly when some pin j in 8..15 has a synchronized level of 1 and mask bit j-8 set.
- R9: The mask register (address 4) holds bits 0..7 only. Write bits 8..15 are dropped and read back as 0.
- R10: Reads of addresses 5 to 7 return 0. Writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` (combinational) |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables, 1 = drive |
| irq | output | 9 | Bits 0..7: per-pin requests; bit 8: merged request |

## Verification
The state that is hardest to reach from the ports is the stopped-clock state outside reset. The reset value and the low-power write both leave the soft reset set, so the bench first takes the bank through 3 then 1, loads known registers and a pad pattern, and then writes 0. Once in that state, it writes new register values and changes the pads, and checks that neither the readback nor the interrupts move. The merged request is checked with masked and unmasked upper pins, including a pin whose mask bit is clear.

// File: rtl/gpio_bank_pkg.sv
// Shared register addresses and widths of the GPIO bank.
// Assumes a 3-bit register address.
package gpio_bank_pkg;
    localparam int CTRL_W = 2;
    localparam int ADDR_W = 3;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 2'b10;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_DIR  = 3'd1,
        A_OUT  = 3'd2,
        A_PINS = 3'd3,
        A_MASK = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
// Control, direction, output and mask registers.
// Assumes: the control register is always writable. The other registers
// clear while the soft reset bit is held and update only while the
// clock enable bit is set.
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS   = 16,
    parameter int N_SHARED = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [N_PINS-1:0]   wdata,
    output logic [CTRL_W-1:0]   ctrl_q,
    output logic [N_PINS-1:0]   dir_q,
    output logic [N_PINS-1:0]   out_q,
    output logic [N_SHARED-1:0] mask_q
);
    logic clk_on;
    logic held;

    assign clk_on = ctrl_q[0];
    assign held   = ctrl_q[1];

    // Control register: reset to the low-power code, then written freely.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RESET;
        else if (wr_en && addr == A_CTRL)
            ctrl_q <= wdata[CTRL_W-1:0];
    end

    // Pin configuration: cleared under soft reset, written only with clock on.
    always_ff @(posedge clk) begin
        if (!rst_n || held) begin
            dir_q  <= '0;
            out_q  <= '0;
            mask_q <= '0;
        end else if (clk_on && wr_en) begin
            if (addr == A_DIR)  dir_q  <= wdata;
            if (addr == A_OUT)  out_q  <= wdata;
            if (addr == A_MASK) mask_q <= wdata[N_SHARED-1:0];
        end
    end

    // R3
    held_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> (dir_q == '0 && out_q == '0 && mask_q == '0));

    // R5
    stopped_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_on && !held) |=> ($stable(dir_q) && $stable(out_q) && $stable(mask_q)));
endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for each pad input.
// Assumes: clear has priority, and the flops hold their value while
// run is low.
module gpio_in_sync #(
    parameter int N_PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clear,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pin_q
);
    logic [N_PINS-1:0] stage1;

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        // Two-stage capture of pad i, frozen when the clock gate is off.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                stage1[i] <= 1'b0;
                pin_q[i]  <= 1'b0;
            end else if (run) begin
                stage1[i] <= pad_in[i];
                pin_q[i]  <= stage1[i];
            end
        end
    end

    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(pin_q));

    // R6
    second_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear) |=> (pin_q == $past(stage1)));
endmodule

// File: rtl/gpio_irq_merge.sv
// Interrupt outputs: one line per lower pin, plus one merged request
// for the upper pins, each upper pin ANDed with its mask bit.
// Assumes the inputs are already synchronized.
module gpio_irq_merge #(
    parameter int N_DIRECT = 8,
    parameter int N_SHARED = 8
) (
    input  logic [N_DIRECT-1:0] direct_pins,
    input  logic [N_SHARED-1:0] shared_pins,
    input  logic [N_SHARED-1:0] mask,
    output logic [N_DIRECT:0]   irq
);
    logic [N_SHARED-1:0] hits;

    for (genvar j = 0; j < N_SHARED; j++) begin : g_hit
        assign hits[j] = shared_pins[j] & mask[j];
    end

    // Lower pins pass straight through; upper hits reduce to one line.
    always_comb begin
        irq[N_DIRECT-1:0] = direct_pins;
        irq[N_DIRECT]     = |hits;
    end
endmodule

// File: rtl/gpio_bank_irq.sv
// Top of the GPIO bank: register port, pad drivers, synchronizer and
// interrupt merge.
// Assumes: reads are combinational, and pins N_DIRECT and up share one
// request line.
module gpio_bank_irq
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS   = 16,
    parameter int N_DIRECT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [N_PINS-1:0]   wdata,
    output logic [N_PINS-1:0]   rd_data,
    input  logic [N_PINS-1:0]   pad_in,
    output logic [N_PINS-1:0]   pad_out,
    output logic [N_PINS-1:0]   pad_oe,
    output logic [N_DIRECT:0]   irq
);
    localparam int N_SHARED = N_PINS - N_DIRECT;

    logic [CTRL_W-1:0]   ctrl_q;
    logic [N_PINS-1:0]   dir_q;
    logic [N_PINS-1:0]   out_q;
    logic [N_SHARED-1:0] mask_q;
    logic [N_PINS-1:0]   pin_q;

    gpio_cfg_regs #(.N_PINS(N_PINS), .N_SHARED(N_SHARED)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ctrl_q(ctrl_q), .dir_q(dir_q), .out_q(out_q), .mask_q(mask_q)
    );

    gpio_in_sync #(.N_PINS(N_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q[0]), .clear(ctrl_q[1]),
        .pad_in(pad_in), .pin_q(pin_q)
    );

    gpio_irq_merge #(.N_DIRECT(N_DIRECT), .N_SHARED(N_SHARED)) u_irq (
        .direct_pins(pin_q[N_DIRECT-1:0]), .shared_pins(pin_q[N_PINS-1:N_DIRECT]),
        .mask(mask_q), .irq(irq)
    );

    assign pad_out = out_q;
    assign pad_oe  = dir_q;

    // Read mux over the register map; unmapped addresses read zero.
    always_comb begin
        case (reg_addr_e'(addr))
            A_CTRL:  rd_data = {{(N_PINS-CTRL_W){1'b0}}, ctrl_q};
            A_DIR:   rd_data = dir_q;
            A_OUT:   rd_data = out_q;
            A_PINS:  rd_data = pin_q;
            A_MASK:  rd_data = {{(N_PINS-N_SHARED){1'b0}}, mask_q};
            default: rd_data = '0;
        endcase
    end

    // R8
    merged_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq[N_DIRECT] |-> (mask_q != '0));

    // R3
    held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[1] |=> (irq == '0));
endmodule

// File: tb/tb_gpio_bank_irq.sv
`timescale 1ns/100ps
module tb_gpio_bank_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] pad_in = 16'h0;
    logic [15:0] rd_data, pad_out, pad_oe;
    logic [8:0]  irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    gpio_bank_irq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq(irq)
    );

    // Behavioural reference: register values and a two-deep pad queue.
    int m_ctrl, m_dir, m_out, m_mask;
    int padq[$];

    function automatic int pins_now();
        return padq.size() >= 2 ? padq[0] : 0;
    endfunction

    initial begin
        m_ctrl = 2; m_dir = 0; m_out = 0; m_mask = 0;
        padq = {0, 0};
    end

    always @(posedge clk) begin
        int old_ctrl;
        old_ctrl = m_ctrl;
        if (!rst_n) begin
            m_ctrl = 2; m_dir = 0; m_out = 0; m_mask = 0; padq = {0, 0};
        end else begin
            if (wr_en && addr == 3'd0) m_ctrl = int'(wdata) % 4;
            if (old_ctrl >= 2) begin
                m_dir = 0; m_out = 0; m_mask = 0; padq = {0, 0};
            end else if (old_ctrl == 1) begin
                if (wr_en && addr == 3'd1) m_dir = int'(wdata);
                if (wr_en && addr == 3'd2) m_out = int'(wdata);
                if (wr_en && addr == 3'd4) m_mask = int'(wdata) % 256;
                padq.push_back(int'(pad_in));
                void'(padq.pop_front());
            end
        end
    end

    function automatic int exp_read(int a);
        case (a)
            0: return m_ctrl;
            1: return m_dir;
            2: return m_out;
            3: return pins_now();
            4: return m_mask;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int p;
            p = pins_now();
            check("R1 pad_oe", int'(pad_oe), m_dir);
            check("R1 pad_out", int'(pad_out), m_out);
            check("R7 irq direct", int'(irq[7:0]), p % 256);
            check("R8 irq merged", int'(irq[8]), ((p / 256) & m_mask) != 0 ? 1 : 0);
            check("R10 rd_data", int'(rd_data), exp_read(int'(addr)));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; addr = 3'(a); wdata = 16'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, int a, int exp);
        addr = 3'(a);
        @(negedge clk);
        check(req, int'(rd_data), exp);
        #0.1;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        rd_chk("R2 ctrl reset", 0, 2);
        rd_chk("R2 dir reset", 1, 0);
        // R3: writes ignored while held in reset
        wr(1, 16'hAAAA);
        rd_chk("R3 dir held", 1, 0);
        // R4: 3 then 1 brings the bank up
        wr(0, 3);
        wr(1, 16'hFFFF);
        rd_chk("R3 dir held clk on", 1, 0);
        wr(0, 1);
        wr(1, 16'h00FF);
        wr(2, 16'h0055);
        wr(4, 16'hFF0F);
        rd_chk("R4 dir", 1, 16'h00FF);
        rd_chk("R1 out", 2, 16'h0055);
        rd_chk("R9 mask upper dropped", 4, 16'h000F);
        check("R1 pad_oe", int'(pad_oe), 16'h00FF);
        // R6: two-cycle latency
        pad_in = 16'h0003;
        addr = 3'd3;
        step();
        rd_chk("R6 one edge", 3, 0);
        step();
        rd_chk("R6 two edges", 3, 16'h0003);
        check("R7 irq lines", int'(irq[7:0]), 3);
        // R8: merged request
        pad_in = 16'h0100; step(); step();
        check("R8 pin8 masked in", int'(irq[8]), 1);
        pad_in = 16'h8000; step(); step();
        check("R8 pin15 masked out", int'(irq[8]), 0);
        pad_in = 16'h0A00; step(); step();
        check("R8 pins9,11", int'(irq[8]), 1);
        // R5: clock stopped, not held
        wr(0, 0);
        wr(1, 16'h1234);
        rd_chk("R5 dir frozen", 1, 16'h00FF);
        pad_in = 16'h0001; step(); step(); step();
        rd_chk("R5 pins frozen", 3, 16'h0A00);
        check("R5 irq frozen", int'(irq), 9'h100);
        // R10: unmapped
        wr(6, 16'hFFFF);
        rd_chk("R10 unmapped", 7, 0);
        rd_chk("R10 unmapped 5", 5, 0);
        // R3: low-power state clears everything
        wr(0, 2);
        step();
        rd_chk("R3 dir cleared", 1, 0);
        rd_chk("R3 mask cleared", 4, 0);
        rd_chk("R3 pins cleared", 3, 0);
        check("R3 irq clear", int'(irq), 0);
        step();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule